// File: doc/BRIEF.md
# Dual-Group Conversion Status Tracker

This block keeps the status of one filter channel that runs two kinds of conversion: a regular group and an inserted group that has higher priority. Software start strobes and conversion-done pulses arrive for each group. The block turns them into in-progress, end-of-conversion and overflow flags, and it keeps the last accepted result of each group in a data register.

It also holds threshold-crossing flags and per-channel clock-loss flags. Each flag is cleared by writing one to a matching clear strobe. When a hardware set and a clear strobe hit the same flag in the same cycle, the set wins.

The flags are packed into one 32-bit status word. An interrupt request is raised from the flags and a per-source enable vector. The filter datapath, the threshold comparators and the serial clock detector are not part of this block; they appear here only as input pulses.

Top module: `conv_status_tracker`

## Requirements
- R1: After reset, every flag is 0, `status_o` is 0, both data registers are 0 and `irq_o` is 0.
- R2: A start strobe on an idle group sets that group's in-progress bit (bit 14 for regular, bit 13 for inserted) at the next clock edge. A done pulse clears the bit at the next clock edge.
- R3: A start strobe on a group whose in-progress bit is 1 is ignored. If the same cycle also carries a done pulse, the in-progress bit goes to 0.
- R4: A done pulse sets the group's end flag (bit 1 regular, bit 0 inserted). If the end flag was 0, the done pulse also loads the result input into the group's data register. A read strobe clears the end flag.
- R5: A done pulse that arrives while the end flag is already 1 sets the group's overflow bit (bit 3 regular, bit 2 inserted). In that case the data register keeps its earlier value.
- R6: An overflow bit stays 1 until its clear strobe is pulsed. A read strobe does not clear it. If a clear strobe and a new overflow fall in the same cycle, the bit stays 1.
- R7: Status bit 4 is 1 while any high-threshold or low-threshold flag is 1. Each flag is set by its own set pulse and cleared by its own clear pulse. If set and clear hit the same flag in the same cycle, the set wins.
- R8: Clock-loss bit k (status bit 16+k) is set by a loss pulse on channel k only while that channel's synchronization-done input is 1. It is cleared by clear bit k. A set wins over a clear in the same cycle.
- R9: Status bits 15, 12 to 5 and 31 to 18 always read 0.
- R10: `irq_o` is the OR of each flag ANDed with its enable bit. The enable bits are: bit 0 regular end, bit 1 inserted end, bit 2 regular overflow, bit 3 inserted overflow, bit 4 threshold event, bit 5 any clock loss.
- R11: A done pulse and a read strobe in the same cycle leave the end flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_start_i | input | 1 | Software start strobe, regular group |
| inj_start_i | input | 1 | Software start strobe, inserted group |
| reg_done_i | input | 1 | Conversion-done pulse, regular group |
| inj_done_i | input | 1 | Conversion-done pulse, inserted group |
| reg_result_i | input | DATA_W | Result delivered with the regular done pulse |
| inj_result_i | input | DATA_W | Result delivered with the inserted done pulse |
| reg_data_rd_i | input | 1 | Read strobe of the regular data register |
| inj_data_rd_i | input | 1 | Read strobe of the inserted data register |
| reg_ovf_clr_i | input | 1 | Clear strobe, regular overflow |
| inj_ovf_clr_i | input | 1 | Clear strobe, inserted overflow |
| thr_hi_set_i | input | NUM_THR | High-threshold crossing pulses |
| thr_lo_set_i | input | NUM_THR | Low-threshold crossing pulses |
| thr_hi_clr_i | input | NUM_THR | Clear strobes, high-threshold flags |
| thr_lo_clr_i | input | NUM_THR | Clear strobes, low-threshold flags |
| sync_done_i | input | NUM_CLK_CH | Serial synchronization complete, per channel |
| clk_lost_i | input | NUM_CLK_CH | Clock-loss pulses, per channel |
| clk_lost_clr_i | input | NUM_CLK_CH | Clear strobes, clock-loss flags |
| irq_en_i | input | 6 | Interrupt enables, one per source |
| status_o | output | 32 | Packed status word |
| reg_data_o | output | DATA_W | Regular data register |
| inj_data_o | output | DATA_W | Inserted data register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives start and done strobes in four ways: sparse random strobes, starts sent to a busy group, done pulses that arrive before the previous result was read, and clears that land in the same cycle as a set. Sparse random traffic confirms that busy bits and end flags move in step. Repeated done pulses without a read show that overflow is raised and that the data register is frozen. A start sent with a done on a busy group tells an ignored start apart from an accepted one. A clear in the same cycle as a set shows which of the two has priority, and a clock-loss pulse with synchronization low confirms that loss is gated by synchronization.

// File: rtl/conv_status_pkg.sv
package conv_status_pkg;
   localparam int unsigned STATUS_W    = 32;
   localparam int unsigned POS_INJ_EOC = 0;
   localparam int unsigned POS_REG_EOC = 1;
   localparam int unsigned POS_INJ_OVF = 2;
   localparam int unsigned POS_REG_OVF = 3;
   localparam int unsigned POS_THR     = 4;
   localparam int unsigned POS_INJ_BSY = 13;
   localparam int unsigned POS_REG_BSY = 14;
   localparam int unsigned POS_CLK_LSB = 16;

   localparam int unsigned EN_REG_EOC = 0;
   localparam int unsigned EN_INJ_EOC = 1;
   localparam int unsigned EN_REG_OVF = 2;
   localparam int unsigned EN_INJ_OVF = 3;
   localparam int unsigned EN_THR     = 4;
   localparam int unsigned EN_CLK     = 5;
   localparam int unsigned IRQ_EN_W   = 6;

   localparam int unsigned GRP_REG = 0;
   localparam int unsigned GRP_INJ = 1;
   localparam int unsigned NUM_GRP = 2;
endpackage

// File: rtl/sticky_flags.sv
module sticky_flags #(
   parameter int unsigned WIDTH    = 2,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] flags_o
);
   logic [WIDTH-1:0] flags_q;
   logic [WIDTH-1:0] flags_d;

   if (WIDTH < 1) begin : g_bad_width
      $error("sticky_flags: WIDTH must be at least 1");
   end

   if (SET_WINS) begin : g_set_wins
      assign flags_d = set_i | (flags_q & ~clr_i);
   end else begin : g_clr_wins
      assign flags_d = (set_i | flags_q) & ~clr_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= flags_d;
   end

   assign flags_o = flags_q;

   for (genvar k = 0; k < WIDTH; k++) begin : g_chk
      if (SET_WINS) begin : g_sw
         AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[k] |=> flags_o[k]);  // R7
      end
      AST_HOLD_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
         flags_o[k] && !clr_i[k] |=> flags_o[k]);  // R8
   end
endmodule

// File: rtl/group_tracker.sv
module group_tracker #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              done_i,
   input  logic [DATA_W-1:0] result_i,
   input  logic              data_rd_i,
   input  logic              ovf_clr_i,
   output logic              busy_o,
   output logic              eoc_o,
   output logic              ovf_o,
   output logic [DATA_W-1:0] data_o
);
   logic              busy_q, eoc_q;
   logic [DATA_W-1:0] data_q;
   logic              ovf_evt;
   logic              load_en;

   if (DATA_W < 1) begin : g_bad_width
      $error("group_tracker: DATA_W must be at least 1");
   end

   assign ovf_evt = done_i & eoc_q;
   assign load_en = done_i & ~eoc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         eoc_q  <= 1'b0;
         data_q <= '0;
      end else begin
         if (busy_q) busy_q <= ~done_i;
         else        busy_q <= start_i;
         eoc_q <= done_i | (eoc_q & ~data_rd_i);
         if (load_en) data_q <= result_i;
      end
   end

   sticky_flags #(.WIDTH(1), .SET_WINS(1'b1)) u_ovf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (ovf_evt),
      .clr_i   (ovf_clr_i),
      .flags_o (ovf_o)
   );

   assign busy_o = busy_q;
   assign eoc_o  = eoc_q;
   assign data_o = data_q;

   AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o && start_i |=> busy_o);  // R2
   AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !done_i |=> busy_o);  // R3
   AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && done_i |=> !busy_o);  // R3
   AST_EOC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> eoc_o);  // R11
   AST_OVF_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i && eoc_o |=> ovf_o);  // R5
   AST_DATA_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i && eoc_o |=> $stable(data_o));  // R5
   AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o && !ovf_clr_i |=> ovf_o);  // R6
endmodule

// File: rtl/conv_status_tracker.sv
module conv_status_tracker
   import conv_status_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_THR    = 2,
   parameter int unsigned NUM_CLK_CH = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  reg_start_i,
   input  logic                  inj_start_i,
   input  logic                  reg_done_i,
   input  logic                  inj_done_i,
   input  logic [DATA_W-1:0]     reg_result_i,
   input  logic [DATA_W-1:0]     inj_result_i,
   input  logic                  reg_data_rd_i,
   input  logic                  inj_data_rd_i,
   input  logic                  reg_ovf_clr_i,
   input  logic                  inj_ovf_clr_i,
   input  logic [NUM_THR-1:0]    thr_hi_set_i,
   input  logic [NUM_THR-1:0]    thr_lo_set_i,
   input  logic [NUM_THR-1:0]    thr_hi_clr_i,
   input  logic [NUM_THR-1:0]    thr_lo_clr_i,
   input  logic [NUM_CLK_CH-1:0] sync_done_i,
   input  logic [NUM_CLK_CH-1:0] clk_lost_i,
   input  logic [NUM_CLK_CH-1:0] clk_lost_clr_i,
   input  logic [IRQ_EN_W-1:0]   irq_en_i,
   output logic [STATUS_W-1:0]   status_o,
   output logic [DATA_W-1:0]     reg_data_o,
   output logic [DATA_W-1:0]     inj_data_o,
   output logic                  irq_o
);
   localparam int unsigned THR_FLAGS = 2 * NUM_THR;

   if (NUM_CLK_CH < 1 || NUM_CLK_CH > STATUS_W - POS_CLK_LSB) begin : g_bad_ch
      $error("conv_status_tracker: NUM_CLK_CH out of range");
   end
   if (NUM_THR < 1) begin : g_bad_thr
      $error("conv_status_tracker: NUM_THR must be at least 1");
   end

   logic [NUM_GRP-1:0] start_v, done_v, rd_v, oclr_v;
   logic [NUM_GRP-1:0] busy_v, eoc_v, ovf_v;
   logic [DATA_W-1:0]  res_v  [NUM_GRP];
   logic [DATA_W-1:0]  data_v [NUM_GRP];

   assign start_v = {inj_start_i,   reg_start_i};
   assign done_v  = {inj_done_i,    reg_done_i};
   assign rd_v    = {inj_data_rd_i, reg_data_rd_i};
   assign oclr_v  = {inj_ovf_clr_i, reg_ovf_clr_i};
   assign res_v[GRP_REG] = reg_result_i;
   assign res_v[GRP_INJ] = inj_result_i;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      group_tracker #(.DATA_W(DATA_W)) u_grp (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .start_i   (start_v[g]),
         .done_i    (done_v[g]),
         .result_i  (res_v[g]),
         .data_rd_i (rd_v[g]),
         .ovf_clr_i (oclr_v[g]),
         .busy_o    (busy_v[g]),
         .eoc_o     (eoc_v[g]),
         .ovf_o     (ovf_v[g]),
         .data_o    (data_v[g])
      );
   end

   logic [THR_FLAGS-1:0] thr_flags;
   sticky_flags #(.WIDTH(THR_FLAGS), .SET_WINS(1'b1)) u_thr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   ({thr_lo_set_i, thr_hi_set_i}),
      .clr_i   ({thr_lo_clr_i, thr_hi_clr_i}),
      .flags_o (thr_flags)
   );

   logic [NUM_CLK_CH-1:0] clk_set, clk_flags;
   assign clk_set = clk_lost_i & sync_done_i;
   sticky_flags #(.WIDTH(NUM_CLK_CH), .SET_WINS(1'b1)) u_clk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (clk_set),
      .clr_i   (clk_lost_clr_i),
      .flags_o (clk_flags)
   );

   logic thr_evt;
   assign thr_evt = |thr_flags;

   always_comb begin
      status_o = '0;
      status_o[POS_REG_BSY] = busy_v[GRP_REG];
      status_o[POS_INJ_BSY] = busy_v[GRP_INJ];
      status_o[POS_THR]     = thr_evt;
      status_o[POS_REG_OVF] = ovf_v[GRP_REG];
      status_o[POS_INJ_OVF] = ovf_v[GRP_INJ];
      status_o[POS_REG_EOC] = eoc_v[GRP_REG];
      status_o[POS_INJ_EOC] = eoc_v[GRP_INJ];
      status_o[POS_CLK_LSB +: NUM_CLK_CH] = clk_flags;
   end

   logic [IRQ_EN_W-1:0] irq_src;
   always_comb begin
      irq_src             = '0;
      irq_src[EN_REG_EOC] = eoc_v[GRP_REG];
      irq_src[EN_INJ_EOC] = eoc_v[GRP_INJ];
      irq_src[EN_REG_OVF] = ovf_v[GRP_REG];
      irq_src[EN_INJ_OVF] = ovf_v[GRP_INJ];
      irq_src[EN_THR]     = thr_evt;
      irq_src[EN_CLK]     = |clk_flags;
   end
   assign irq_o = |(irq_src & irq_en_i);

   assign reg_data_o = data_v[GRP_REG];
   assign inj_data_o = data_v[GRP_INJ];

   for (genvar k = 0; k < NUM_CLK_CH; k++) begin : g_clk_chk
      AST_LOSS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !status_o[POS_CLK_LSB+k] && !sync_done_i[k] |=> !status_o[POS_CLK_LSB+k]);  // R8
   end
   AST_THR_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|thr_hi_set_i || |thr_lo_set_i) |=> status_o[POS_THR]);  // R7
   AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (irq_en_i != '0));  // R10
endmodule

// File: tb/conv_status_tracker_tb_top.sv
module conv_status_tracker_tb_top;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          reg_start, inj_start, reg_done, inj_done;
   logic [DW-1:0] reg_res, inj_res;
   logic          reg_rd, inj_rd, reg_oclr, inj_oclr;
   logic [1:0]    hi_set, lo_set, hi_clr, lo_clr, sync, lost, lost_clr;
   logic [5:0]    en;
   logic [31:0]   status;
   logic [DW-1:0] reg_data, inj_data;
   logic          irq;

   conv_status_tracker #(.DATA_W(DW), .NUM_THR(2), .NUM_CLK_CH(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .reg_start_i(reg_start), .inj_start_i(inj_start),
      .reg_done_i(reg_done), .inj_done_i(inj_done),
      .reg_result_i(reg_res), .inj_result_i(inj_res),
      .reg_data_rd_i(reg_rd), .inj_data_rd_i(inj_rd),
      .reg_ovf_clr_i(reg_oclr), .inj_ovf_clr_i(inj_oclr),
      .thr_hi_set_i(hi_set), .thr_lo_set_i(lo_set),
      .thr_hi_clr_i(hi_clr), .thr_lo_clr_i(lo_clr),
      .sync_done_i(sync), .clk_lost_i(lost), .clk_lost_clr_i(lost_clr),
      .irq_en_i(en), .status_o(status),
      .reg_data_o(reg_data), .inj_data_o(inj_data), .irq_o(irq)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // model state: index 0 regular, 1 inserted
   logic [1:0]    m_busy, m_eoc, m_ovf;
   logic [DW-1:0] m_data [2];
   logic [1:0]    m_hi, m_lo, m_cl;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_status();
      logic [31:0] s;
      s = '0;
      s[14] = m_busy[0]; s[13] = m_busy[1];
      s[4]  = |{m_hi, m_lo};
      s[3]  = m_ovf[0]; s[2] = m_ovf[1];
      s[1]  = m_eoc[0]; s[0] = m_eoc[1];
      s[17:16] = m_cl;
      return s;
   endfunction

   function automatic logic exp_irq();
      logic [5:0] src;
      src = {|m_cl, |{m_hi, m_lo}, m_ovf[1], m_ovf[0], m_eoc[1], m_eoc[0]};
      return |(src & en);
   endfunction

   task automatic idle_inputs();
      reg_start = 0; inj_start = 0; reg_done = 0; inj_done = 0;
      reg_rd = 0; inj_rd = 0; reg_oclr = 0; inj_oclr = 0;
      hi_set = 0; lo_set = 0; hi_clr = 0; lo_clr = 0;
      lost = 0; lost_clr = 0;
   endtask

   task automatic compare_all();
      logic [31:0] e;
      e = exp_status();
      check(status[14:13] == e[14:13], "R2 busy bits", status, e);
      check(status[1:0] == e[1:0], "R4 end flags", status, e);
      check(status[3:2] == e[3:2], "R6 overflow bits", status, e);
      check(reg_data == m_data[0] && inj_data == m_data[1], "R5 data registers",
            {reg_data, inj_data}, {m_data[0], m_data[1]});
      check(status[4] == e[4], "R7 threshold event", status, e);
      check(status[17:16] == e[17:16], "R8 clock loss", status, e);
      check(status[15] == 1'b0 && status[12:5] == '0 && status[31:18] == '0,
            "R9 reserved bits", status, e);
      check(irq == exp_irq(), "R10 irq", {31'd0, irq}, {31'd0, exp_irq()});
   endtask

   // one clock: inputs already driven (at a negedge); model advanced; compare at next negedge
   task automatic step();
      logic [1:0] st, dn, rd, oc;
      logic [DW-1:0] rs [2];
      logic [1:0] nb, ne, no;
      logic [DW-1:0] nd [2];
      st = {inj_start, reg_start}; dn = {inj_done, reg_done};
      rd = {inj_rd, reg_rd};       oc = {inj_oclr, reg_oclr};
      rs[0] = reg_res; rs[1] = inj_res;
      for (int g = 0; g < 2; g++) begin
         nb[g] = m_busy[g] ? ~dn[g] : st[g];
         ne[g] = dn[g] | (m_eoc[g] & ~rd[g]);
         no[g] = (dn[g] & m_eoc[g]) | (m_ovf[g] & ~oc[g]);
         nd[g] = (dn[g] & ~m_eoc[g]) ? rs[g] : m_data[g];
      end
      @(posedge clk);
      m_busy = nb; m_eoc = ne; m_ovf = no; m_data[0] = nd[0]; m_data[1] = nd[1];
      m_hi = hi_set | (m_hi & ~hi_clr);
      m_lo = lo_set | (m_lo & ~lo_clr);
      m_cl = (lost & sync) | (m_cl & ~lost_clr);
      @(negedge clk);
      compare_all();
      idle_inputs();
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      idle_inputs();
      sync = 2'b11; en = 6'b111111;
      reg_res = 16'h1111; inj_res = 16'h2222;
      m_busy = 0; m_eoc = 0; m_ovf = 0; m_hi = 0; m_lo = 0; m_cl = 0;
      m_data[0] = '0; m_data[1] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(status == 32'd0, "R1 status after reset", status, 32'd0);
      check(reg_data == '0 && inj_data == '0, "R1 data after reset", {reg_data, inj_data}, 32'd0);
      check(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: start sets busy
      reg_start = 1; step();
      check(status[14] == 1'b1, "R2 regular busy after start", status, 32'h4000);
      // R3: start+done while busy -> busy clears
      reg_start = 1; reg_done = 1; reg_res = 16'hA5A5; step();
      check(status[14] == 1'b0, "R3 start ignored while busy", status, 32'h0);
      check(reg_data == 16'hA5A5 && status[1], "R4 data loaded and end set", {16'd0, reg_data}, 32'hA5A5);
      // R5: done while end set -> overflow, data kept
      reg_done = 1; reg_res = 16'h5A5A; step();
      check(status[3] == 1'b1 && reg_data == 16'hA5A5, "R5 overflow keeps data", {status[15:0], reg_data}, 32'h000AA5A5);
      // R6: read does not clear overflow; set wins over clear
      reg_rd = 1; step();
      check(status[3] == 1'b1 && status[1] == 1'b0, "R6 read leaves overflow", status, 32'h8);
      reg_done = 1; step();
      reg_done = 1; reg_oclr = 1; step();
      check(status[3] == 1'b1, "R6 set wins over clear", status, 32'h8);
      reg_oclr = 1; reg_rd = 1; step();
      check(status[3] == 1'b0, "R6 overflow cleared", status, 32'h0);
      // R11: done and read together keep end flag
      inj_done = 1; inj_res = 16'h3C3C; step();
      inj_done = 1; inj_rd = 1; step();
      check(status[0] == 1'b1, "R11 end flag set wins over read", status, 32'h1);
      // R8: loss without sync ignored
      sync = 2'b01; lost = 2'b10; step();
      check(status[17] == 1'b0, "R8 loss ignored without sync", status, 32'h0);
      lost = 2'b01; lost_clr = 2'b01; step();
      check(status[16] == 1'b1, "R8 loss set wins over clear", status, 32'h10000);
      // R7: threshold OR drops only when all cleared
      hi_set = 2'b10; lo_set = 2'b01; step();
      hi_clr = 2'b10; step();
      check(status[4] == 1'b1, "R7 event held by remaining flag", status, 32'h10);
      lo_clr = 2'b01; step();
      check(status[4] == 1'b0, "R7 event cleared", status, 32'h0);
      // R10: irq masked
      en = 6'b000000; @(negedge clk); compare_all();
      check(irq == 1'b0, "R10 irq masked", {31'd0, irq}, 32'd0);

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         reg_start = ($urandom % 4) == 0;
         inj_start = ($urandom % 4) == 0;
         reg_done  = ($urandom % 5) == 0;
         inj_done  = ($urandom % 5) == 0;
         reg_res   = DW'($urandom);
         inj_res   = DW'($urandom);
         reg_rd    = ($urandom % 4) == 0;
         inj_rd    = ($urandom % 4) == 0;
         reg_oclr  = ($urandom % 6) == 0;
         inj_oclr  = ($urandom % 6) == 0;
         hi_set    = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
         lo_set    = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
         hi_clr    = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
         lo_clr    = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
         sync      = 2'($urandom);
         lost      = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
         lost_clr  = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
         en        = 6'($urandom);
         step();
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule